// File: doc/BRIEF.md
# Vector Pairwise Sum and Deinterleave Unit

This unit reshapes two source vectors into one destination vector, one lane at a time. The caller picks a lane size, a register width of 64 or 128 bits, and one of three operations. Pairwise-sum adds each adjacent pair of source lanes. Even-deinterleave keeps the even-numbered lanes, and odd-deinterleave keeps the odd-numbered lanes. The lower half of the destination lanes always draws from the first source, `src_a`. The upper half draws from the second source, `src_b`. Destination lane `i` reads the pair at source lanes `2*(i mod half)` and `2*(i mod half)+1`.

All lane and size variants are computed in parallel, and the requested variant is selected. The result is captured in a register when `in_valid` is high. A two-state controller raises `out_valid` for exactly one cycle after each accepted input. The controller has state IDLE and state EMIT. The transition IDLE→EMIT or EMIT→EMIT (accept) is taken when `in_valid` is high. The transition EMIT→IDLE or IDLE→IDLE (drain) is taken when it is low. `out_valid` is high only in EMIT.

Top module: `vec_pairperm`

## Requirements
- R1: The size code `size_sel` s selects a lane width of 8<<s bits (0:8, 1:16, 2:32, 3:64). The lane count is (register bytes)>>s, where `wide`=1 means 128-bit and `wide`=0 means 64-bit. Lanes are numbered from bit 0 upward.
- R2: With `op_sel`=0 (pairwise sum), destination lane i is the sum of lanes 2*(i mod half) and 2*(i mod half)+1. The source is `src_a` for i < half and `src_b` otherwise. The sum wraps modulo 2^(lane width) with no carry out.
- R3: With `op_sel`=1 (even deinterleave), destination lane i equals source lane 2*(i mod half), using the same source split as R2.
- R4: With `op_sel`=2 (odd deinterleave), destination lane i equals source lane 2*(i mod half)+1, using the same source split as R2.
- R5: With `wide`=0, only the low 64 bits of each source are used, and result bits [127:64] are zero.
- R6: `size_sel`=3 together with `wide`=0 sets `illegal`=1 and gives an all-zero result.
- R7: `op_sel`=3 is reserved. It sets `illegal`=1 and gives an all-zero result.
- R8: `result` and `illegal` update on the first rising edge at which `in_valid` is high, and `out_valid` is high in the cycle that follows. Without `in_valid`, `out_valid` is low and `result` and `illegal` hold their values.
- R9: After reset, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| op_sel | input | 2 | 0 pairwise sum, 1 even deinterleave, 2 odd deinterleave, 3 reserved |
| size_sel | input | 2 | Lane size code |
| wide | input | 1 | 1 = 128-bit register, 0 = 64-bit register |
| src_a | input | 128 | First source vector (feeds lower destination lanes) |
| src_b | input | 128 | Second source vector (feeds upper destination lanes) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| illegal | output | 1 | Registered flag for an illegal size/width or op combination |
| result | output | 128 | Registered destination vector |

## Verification
The assertions check the one-cycle strobe relationship and the holding of the result when no input arrives, on every cycle. They also check that an illegal flag always comes with a zero result, and that a 64-bit-mode result always has a zero upper half. Lane values cannot be checked that way. Pairwise sums and their wrap, the picking of even and odd lanes, and the split between the two sources are shown only by the bench. The bench sweeps every op, size and width against an arithmetic model using varied data.

// File: rtl/vec_pairperm_pkg.sv
package vec_pairperm_pkg;
    localparam int VEC_W     = 128;
    localparam int NARROW_W  = 64;
    localparam int NUM_SIZES = 4;

    typedef enum logic [1:0] {
        OP_PSUM = 2'd0,
        OP_EVEN = 2'd1,
        OP_ODD  = 2'd2,
        OP_RSV  = 2'd3
    } pp_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } pp_state_e;
endpackage

// File: rtl/vec_pairperm_lanes.sv
module vec_pairperm_lanes
    import vec_pairperm_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int REG_W  = 128,
    parameter int OUT_W  = 128
) (
    input  pp_op_e             op,
    input  logic [REG_W-1:0]   a_vec,
    input  logic [REG_W-1:0]   b_vec,
    output logic [OUT_W-1:0]   y_vec
);
    localparam int NLANE = REG_W / LANE_W;
    localparam int HALF  = NLANE / 2;

    logic [REG_W-1:0] core;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        localparam int J = 2 * (i % HALF);
        logic [LANE_W-1:0] lo_l, hi_l, pick;
        if (i < HALF) begin : g_src_a
            assign lo_l = a_vec[J*LANE_W +: LANE_W];
            assign hi_l = a_vec[(J+1)*LANE_W +: LANE_W];
        end else begin : g_src_b
            assign lo_l = b_vec[J*LANE_W +: LANE_W];
            assign hi_l = b_vec[(J+1)*LANE_W +: LANE_W];
        end
        always_comb begin
            unique case (op)
                OP_PSUM: pick = lo_l + hi_l;
                OP_EVEN: pick = lo_l;
                OP_ODD:  pick = hi_l;
                default: pick = '0;
            endcase
        end
        assign core[i*LANE_W +: LANE_W] = pick;
    end

    if (REG_W < OUT_W) begin : g_pad
        assign y_vec = {{(OUT_W-REG_W){1'b0}}, core};
    end else begin : g_full
        assign y_vec = core;
    end
endmodule

// File: rtl/vec_pairperm_ctrl.sv
module vec_pairperm_ctrl
    import vec_pairperm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic capture,
    output logic out_valid
);
    pp_state_e state, state_nx;

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        capture   = in_valid;
        out_valid = (state == ST_EMIT);
    end

    a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/vec_pairperm.sv
module vec_pairperm
    import vec_pairperm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op_sel,
    input  logic [1:0]   size_sel,
    input  logic         wide,
    input  logic [127:0] src_a,
    input  logic [127:0] src_b,
    output logic         out_valid,
    output logic         illegal,
    output logic [127:0] result
);
    localparam int NW = 2;

    pp_op_e           op;
    logic [VEC_W-1:0] cand [NW][NUM_SIZES];
    logic [VEC_W-1:0] res_nx;
    logic             bad_nx;
    logic             capture;

    assign op = pp_op_e'(op_sel);

    for (genvar w = 0; w < NW; w++) begin : g_width
        localparam int RW = (w == 1) ? VEC_W : NARROW_W;
        for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
            localparam int LW = 8 << s;
            if (2 * LW <= RW) begin : g_ok
                vec_pairperm_lanes #(.LANE_W(LW), .REG_W(RW), .OUT_W(VEC_W)) u_lanes (
                    .op    (op),
                    .a_vec (src_a[RW-1:0]),
                    .b_vec (src_b[RW-1:0]),
                    .y_vec (cand[w][s])
                );
            end else begin : g_none
                assign cand[w][s] = '0;
            end
        end
    end

    always_comb begin
        bad_nx = (op == OP_RSV) || (!wide && size_sel == 2'd3);
        res_nx = bad_nx ? '0 : cand[wide][size_sel];
    end

    vec_pairperm_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .capture   (capture),
        .out_valid (out_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            illegal <= 1'b0;
        end else if (capture) begin
            result  <= res_nx;
            illegal <= bad_nx;
        end
    end

    a_r6_r7_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0));
    a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (result[127:64] == '0));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal)));
endmodule

// File: tb/vec_pairperm_bench.sv
module vec_pairperm_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op_sel = '0;
    logic [1:0]   size_sel = '0;
    logic         wide = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         out_valid;
    logic         illegal;
    logic [127:0] result;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vec_pairperm u_vec_pairperm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .size_sel(size_sel), .wide(wide), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .illegal(illegal), .result(result)
    );

    function automatic logic [127:0] model(input int op, input int sz, input bit w,
                                           input logic [127:0] a, input logic [127:0] b);
        int lw = 8 << sz;
        int nl = (w ? 16 : 8) >> sz;
        int half;
        logic [127:0] mask, r, src, x, y, v;
        r = '0;
        if (op == 3 || (!w && sz == 3)) return r;
        half = nl / 2;
        mask = (lw == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << lw) - 128'd1);
        for (int i = 0; i < nl; i++) begin
            int j = 2 * (i % half);
            src = (i < half) ? a : b;
            if (!w) src = src & {64'd0, {64{1'b1}}};
            x = (src >> (j * lw)) & mask;
            y = (src >> ((j + 1) * lw)) & mask;
            v = (op == 0) ? ((x + y) & mask) : (op == 1) ? x : y;
            r = r | (v << (i * lw));
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(input int op, input int sz, input bit w,
                           input logic [127:0] a, input logic [127:0] b);
        logic [127:0] exp;
        string tag;
        bit bad;
        bad = (op == 3) || (!w && sz == 3);
        exp = model(op, sz, w, a, b);
        if (op == 3) tag = "R7";
        else if (bad) tag = "R6";
        else if (op == 0) tag = "R1/R2";
        else if (op == 1) tag = "R1/R3";
        else tag = "R1/R4";
        @(negedge clk);
        in_valid = 1'b1; op_sel = 2'(op); size_sel = 2'(sz); wide = w;
        src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        src_a = ~a; src_b = ~b;
        check($sformatf("%s result op=%0d sz=%0d w=%0d", tag, op, sz, w), result, exp);
        check($sformatf("%s illegal flag", tag), {127'd0, illegal}, {127'd0, bad});
        check("R8 out_valid after strobe", {127'd0, out_valid}, 128'd1);
        if (!w) check("R5 upper half zero", {64'd0, result[127:64]}, 128'd0);
        @(negedge clk);
        check("R8 out_valid drops", {127'd0, out_valid}, 128'd0);
        check("R8 result held", result, exp);
    endtask

    initial begin
        logic [127:0] pa, pb;
        #5;
        check("R9 reset out_valid", {127'd0, out_valid}, 128'd0);
        check("R9 reset illegal", {127'd0, illegal}, 128'd0);
        check("R9 reset result", result, 128'd0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 5; p++) begin
            for (int k = 0; k < 16; k++) begin
                case (p)
                    0: begin pa[k*8 +: 8] = 8'(k); pb[k*8 +: 8] = 8'(8'h80 + k); end
                    1: begin pa[k*8 +: 8] = 8'hFF; pb[k*8 +: 8] = 8'hFF; end
                    2: begin pa[k*8 +: 8] = (k % 2) ? 8'hAA : 8'h55; pb[k*8 +: 8] = 8'(k * 17); end
                    default: begin pa[k*8 +: 8] = 8'($urandom); pb[k*8 +: 8] = 8'($urandom); end
                endcase
            end
            for (int op = 0; op < 4; op++)
                for (int sz = 0; sz < 4; sz++)
                    for (int w = 0; w < 2; w++)
                        run_one(op, sz, w[0], pa, pb);
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule